// File: doc/BRIEF.md
# Fault escalation and lockup controller

This block makes the control decisions for faults in a small processor core. Three kinds of configurable fault reach it as single-cycle pulses: memory-protection, bus and usage. For each pulse it decides one of three outcomes. The fault may be served by its own handler. It may be escalated to the fixed-priority hard fault. Or, when the core is already inside the NMI or hard-fault handler, the fault may freeze the core in lockup, where the execute enable is removed.

The decision uses the handler context, the enable and priority of each fault, and the current execution priority. The chosen exceptions are kept pending and issued one at a time on a one-hot take vector, ordered NMI, hard, memory, bus, usage. The block also keeps sticky status bits, which software clears by writing ones. There is a combined 32-bit configurable status word and a 2-bit hard status word. A held fault address is kept for memory faults and another for bus faults.

Top module: `flt_escalate_ctl`

## Requirements
- R1: After reset the outputs are as follows: take_o is 0, lockup_o is 0, exec_en_o is 1, cfsr_o is 0 and hfsr_o is 0.
- R2: A fault may be served by its own handler. This happens when the context is thread (ctx 0) or another handler (ctx 3), the fault is enabled (en_i bit0 memory, bit1 bus, bit2 usage) and its priority is numerically below exec_pri_i. The fault then sets its status flag one edge after the pulse: cfsr_o bit0 for memory, bit8 for bus, bit16 for usage. Two edges after the pulse, take_o raises that fault's bit: bit2 memory, bit3 bus, bit4 usage.
- R3: A configurable fault that is disabled, or whose priority is not below exec_pri_i, is escalated. Escalation sets hfsr_o bit0 (forced) one edge after the pulse. Two edges after the pulse, take_o bit1 (hard) is raised.
- R4: Inside the NMI handler (ctx 1) or the hard-fault handler (ctx 2), every configurable fault escalates, and the escalation enters lockup instead. One edge later lockup_o is 1, exec_en_o is 0 and hfsr_o is 3. While locked, nothing is taken unless an NMI releases the lock.
- R5: A debugger halt pulse or a reset releases lockup in every case.
- R6: An NMI pulse releases a lockup that was entered from the hard-fault handler, and the NMI is taken. If the lockup was entered from the NMI handler, an NMI pulse leaves it locked and nothing is taken.
- R7: Takes are one-hot, one per cycle, in the order NMI (bit0), hard, memory, bus, usage. An NMI pulse outside lockup is taken on the next edge.
- R8: A bus fault with bus_stk_i set is served by the bus handler even when it would otherwise escalate. It sets cfsr_o bit8 and bit12, does not set bit15 and leaves hfsr_o and bus_far_o unchanged.
- R9: A memory fault loads flt_addr_i into mem_far_o and sets cfsr_o bit7. A bus fault without bus_stk_i does the same into bus_far_o and sets bit15. While the valid bit is set, a later fault does not change the held address.
- R10: A one in cfsr_clr_i or hfsr_clr_i clears the matching status bit on the next edge. A bit that is set in the same cycle as it is cleared stays set.
- R11: Fault pulses that arrive while locked change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flt_mem_i | input | 1 | Memory-protection fault pulse |
| flt_bus_i | input | 1 | Bus fault pulse |
| flt_use_i | input | 1 | Usage fault pulse |
| bus_stk_i | input | 1 | Bus fault arose while pushing the stack on entry to the bus handler |
| flt_addr_i | input | AW | Address of the faulting access |
| ctx_i | input | 2 | Context: 0 thread, 1 NMI handler, 2 hard handler, 3 other handler |
| exec_pri_i | input | PW | Current execution priority, lower is more urgent |
| en_i | input | 3 | Handler enables: memory, bus, usage |
| mem_pri_i | input | PW | Memory fault priority |
| bus_pri_i | input | PW | Bus fault priority |
| use_pri_i | input | PW | Usage fault priority |
| nmi_i | input | 1 | NMI pulse |
| dbg_halt_i | input | 1 | Debugger halt pulse |
| cfsr_clr_i | input | 32 | Write-one-to-clear mask for cfsr_o |
| hfsr_clr_i | input | 2 | Write-one-to-clear mask for hfsr_o |
| take_o | output | 5 | One-hot exception taken |
| lockup_o | output | 1 | Core is locked up |
| exec_en_o | output | 1 | Instruction execute enable |
| cfsr_o | output | 32 | Combined configurable fault status |
| hfsr_o | output | 2 | Hard status: bit0 forced, bit1 lockup cause |
| mem_far_o | output | AW | Held memory fault address |
| bus_far_o | output | AW | Held bus fault address |

## Verification
The properties assume that nmi_i and dbg_halt_i are single-cycle pulses. They also assume that a fault pulse is never held across an edge, so that a level is not counted as a fresh event. The stimulus drives every pulse for exactly one clock and returns it to zero before the next edge. The same holds for the clear masks, so a clear never overlaps the check of a sticky bit. Context, enables and priorities only change while no fault pulse is present. Each scenario also clears stale status and lets the pending exceptions drain before it starts.

// File: rtl/flt_pkg.sv
package flt_pkg;
   typedef enum logic [1:0] {
      CTX_THREAD = 2'd0,
      CTX_NMI    = 2'd1,
      CTX_HARD   = 2'd2,
      CTX_OTHER  = 2'd3
   } ctx_e;

   localparam int NCH     = 3;
   localparam int CH_MEM  = 0;
   localparam int CH_BUS  = 1;
   localparam int CH_USE  = 2;

   localparam int NEXC    = 5;
   localparam int EX_NMI  = 0;
   localparam int EX_HARD = 1;
   localparam int EX_MEM  = 2;
   localparam int EX_BUS  = 3;
   localparam int EX_USE  = 4;

   localparam int CFSR_W        = 32;
   localparam int MEM_FLT_BIT   = 0;
   localparam int MEM_VALID_BIT = 7;
   localparam int BUS_FLT_BIT   = 8;
   localparam int BUS_STK_BIT   = 12;
   localparam int BUS_VALID_BIT = 15;
   localparam int USE_FLT_BIT   = 16;

   localparam int HFSR_W     = 2;
   localparam int HF_FORCED  = 0;
   localparam int HF_LOCK    = 1;
endpackage

// File: rtl/flt_esc_chan.sv
module flt_esc_chan #(
   parameter int PW = 3
) (
   input  logic          fault_i,
   input  logic          en_i,
   input  logic [PW-1:0] pri_i,
   input  logic [PW-1:0] exec_pri_i,
   input  logic [1:0]    ctx_i,
   input  logic          bypass_i,
   output logic          own_o,
   output logic          esc_o
);
   logic fixed_ctx;
   logic pri_ok;

   always_comb begin
      fixed_ctx = (ctx_i == flt_pkg::CTX_NMI) || (ctx_i == flt_pkg::CTX_HARD);
      pri_ok    = en_i && (pri_i < exec_pri_i) && !fixed_ctx;
      own_o     = fault_i && (pri_ok || bypass_i);
      esc_o     = fault_i && !pri_ok && !bypass_i;
   end
endmodule

// File: rtl/flt_addr_cap.sv
module flt_addr_cap #(
   parameter int AW   = 32,
   parameter bit HOLD = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cap_i,
   input  logic          valid_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] far_o
);
   logic load;

   generate
      if (HOLD) begin : g_hold
         assign load = cap_i && !valid_i;
      end else begin : g_over
         logic unused_valid;
         assign unused_valid = valid_i;
         assign load = cap_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   far_o <= '0;
      else if (load) far_o <= addr_i;
   end
endmodule

// File: rtl/flt_prio_arb.sv
module flt_prio_arb #(
   parameter int N = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:1] req_i,
   input  logic         nmi_i,
   input  logic         gnt_en_i,
   output logic [N-1:0] take_o
);
   logic [N-1:1] pend_q;
   logic [N-1:0] cand;
   logic [N-1:0] gnt;
   logic         found;

   always_comb begin
      cand  = {pend_q, nmi_i};
      gnt   = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (gnt_en_i && cand[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         take_o <= '0;
      end else begin
         pend_q <= (pend_q & ~gnt[N-1:1]) | req_i;
         take_o <= gnt;
      end
   end
endmodule

// File: rtl/flt_lockup.sv
module flt_lockup (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enter_i,
   input  logic from_nmi_i,
   input  logic nmi_i,
   input  logic dbg_halt_i,
   output logic lock_o,
   output logic from_nmi_o,
   output logic nmi_rel_o
);
   assign nmi_rel_o = lock_o && nmi_i && !from_nmi_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_o     <= 1'b0;
         from_nmi_o <= 1'b0;
      end else if (lock_o) begin
         if (dbg_halt_i || nmi_rel_o) begin
            lock_o     <= 1'b0;
            from_nmi_o <= 1'b0;
         end
      end else if (enter_i) begin
         lock_o     <= 1'b1;
         from_nmi_o <= from_nmi_i;
      end
   end
endmodule

// File: rtl/flt_escalate_ctl.sv
module flt_escalate_ctl #(
   parameter int AW       = 32,
   parameter int PW       = 3,
   parameter bit FAR_HOLD = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          flt_mem_i,
   input  logic          flt_bus_i,
   input  logic          flt_use_i,
   input  logic          bus_stk_i,
   input  logic [AW-1:0] flt_addr_i,
   input  logic [1:0]    ctx_i,
   input  logic [PW-1:0] exec_pri_i,
   input  logic [2:0]    en_i,
   input  logic [PW-1:0] mem_pri_i,
   input  logic [PW-1:0] bus_pri_i,
   input  logic [PW-1:0] use_pri_i,
   input  logic          nmi_i,
   input  logic          dbg_halt_i,
   input  logic [31:0]   cfsr_clr_i,
   input  logic [1:0]    hfsr_clr_i,
   output logic [4:0]    take_o,
   output logic          lockup_o,
   output logic          exec_en_o,
   output logic [31:0]   cfsr_o,
   output logic [1:0]    hfsr_o,
   output logic [AW-1:0] mem_far_o,
   output logic [AW-1:0] bus_far_o
);
   import flt_pkg::*;

   localparam logic [CFSR_W-1:0] CFSR_MASK =
      (CFSR_W'(1) << MEM_FLT_BIT) | (CFSR_W'(1) << MEM_VALID_BIT) |
      (CFSR_W'(1) << BUS_FLT_BIT) | (CFSR_W'(1) << BUS_STK_BIT)   |
      (CFSR_W'(1) << BUS_VALID_BIT) | (CFSR_W'(1) << USE_FLT_BIT);

   generate
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("flt_escalate_ctl: AW out of range");
      end
      if (PW < 1 || PW > 8) begin : g_bad_pw
         $error("flt_escalate_ctl: PW out of range");
      end
   endgenerate

   logic [NCH-1:0]    flt;
   logic [NCH-1:0]    own;
   logic [NCH-1:0]    esc;
   logic [NCH-1:0]    bypass;
   logic [PW-1:0]     pri [NCH];
   logic              hreq;
   logic              fixed_ctx;
   logic              lock_enter;
   logic              lock_from_nmi;
   logic              nmi_rel;
   logic [NEXC-1:1]   req;
   logic [CFSR_W-1:0] cfsr_q;
   logic [CFSR_W-1:0] cfsr_set;
   logic [HFSR_W-1:0] hfsr_q;
   logic [HFSR_W-1:0] hfsr_set;

   always_comb begin
      flt[CH_MEM]    = flt_mem_i && !lockup_o;
      flt[CH_BUS]    = flt_bus_i && !lockup_o;
      flt[CH_USE]    = flt_use_i && !lockup_o;
      bypass         = '0;
      bypass[CH_BUS] = bus_stk_i;
      pri[CH_MEM]    = mem_pri_i;
      pri[CH_BUS]    = bus_pri_i;
      pri[CH_USE]    = use_pri_i;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      flt_esc_chan #(.PW(PW)) u_chan (
         .fault_i   (flt[c]),
         .en_i      (en_i[c]),
         .pri_i     (pri[c]),
         .exec_pri_i(exec_pri_i),
         .ctx_i     (ctx_i),
         .bypass_i  (bypass[c]),
         .own_o     (own[c]),
         .esc_o     (esc[c])
      );
   end

   always_comb begin
      hreq         = |esc;
      fixed_ctx    = (ctx_i == CTX_NMI) || (ctx_i == CTX_HARD);
      lock_enter   = hreq && fixed_ctx;
      req[EX_HARD] = hreq && !fixed_ctx;
      req[EX_MEM]  = own[CH_MEM];
      req[EX_BUS]  = own[CH_BUS];
      req[EX_USE]  = own[CH_USE];

      cfsr_set                = '0;
      cfsr_set[MEM_FLT_BIT]   = flt[CH_MEM];
      cfsr_set[MEM_VALID_BIT] = flt[CH_MEM];
      cfsr_set[BUS_FLT_BIT]   = flt[CH_BUS];
      cfsr_set[BUS_STK_BIT]   = flt[CH_BUS] && bus_stk_i;
      cfsr_set[BUS_VALID_BIT] = flt[CH_BUS] && !bus_stk_i;
      cfsr_set[USE_FLT_BIT]   = flt[CH_USE];
      hfsr_set[HF_FORCED]     = hreq;
      hfsr_set[HF_LOCK]       = lock_enter;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfsr_q <= '0;
         hfsr_q <= '0;
      end else begin
         cfsr_q <= ((cfsr_q & ~cfsr_clr_i) | cfsr_set) & CFSR_MASK;
         hfsr_q <= (hfsr_q & ~hfsr_clr_i) | hfsr_set;
      end
   end

   flt_lockup u_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .enter_i   (lock_enter),
      .from_nmi_i(ctx_i == CTX_NMI),
      .nmi_i     (nmi_i),
      .dbg_halt_i(dbg_halt_i),
      .lock_o    (lockup_o),
      .from_nmi_o(lock_from_nmi),
      .nmi_rel_o (nmi_rel)
   );

   flt_prio_arb #(.N(NEXC)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req),
      .nmi_i   (nmi_i),
      .gnt_en_i(!lockup_o || nmi_rel),
      .take_o  (take_o)
   );

   flt_addr_cap #(.AW(AW), .HOLD(FAR_HOLD)) u_mem_far (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (flt[CH_MEM]),
      .valid_i(cfsr_q[MEM_VALID_BIT]),
      .addr_i (flt_addr_i),
      .far_o  (mem_far_o)
   );

   flt_addr_cap #(.AW(AW), .HOLD(FAR_HOLD)) u_bus_far (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (flt[CH_BUS] && !bus_stk_i),
      .valid_i(cfsr_q[BUS_VALID_BIT]),
      .addr_i (flt_addr_i),
      .far_o  (bus_far_o)
   );

   assign exec_en_o = !lockup_o;
   assign cfsr_o    = cfsr_q;
   assign hfsr_o    = hfsr_q;
endmodule

// File: rtl/flt_escalate_ctl_chk.sv
module flt_escalate_ctl_chk #(
   parameter int AW   = 32,
   parameter bit HOLD = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          nmi_i,
   input logic          dbg_halt_i,
   input logic [4:0]    take_o,
   input logic          lockup_o,
   input logic          lock_nmi,
   input logic          forced,
   input logic          forced_clr,
   input logic          mem_valid,
   input logic          mem_valid_clr,
   input logic [AW-1:0] mem_far_o
);
   p_take_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(take_o));

   p_nmi_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_i && !lockup_o |=> take_o[0]);

   p_no_take_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lockup_o && !nmi_i |=> take_o == 5'd0);

   p_dbg_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lockup_o && dbg_halt_i |=> !lockup_o);

   p_nmi_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lockup_o && lock_nmi && !dbg_halt_i |=> lockup_o);

   p_forced_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      forced && !forced_clr |=> forced);

   p_far_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      HOLD && mem_valid && !mem_valid_clr |=> $stable(mem_far_o));
endmodule

bind flt_escalate_ctl flt_escalate_ctl_chk #(.AW(AW), .HOLD(FAR_HOLD)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .nmi_i        (nmi_i),
   .dbg_halt_i   (dbg_halt_i),
   .take_o       (take_o),
   .lockup_o     (lockup_o),
   .lock_nmi     (lock_from_nmi),
   .forced       (hfsr_o[flt_pkg::HF_FORCED]),
   .forced_clr   (hfsr_clr_i[flt_pkg::HF_FORCED]),
   .mem_valid    (cfsr_o[flt_pkg::MEM_VALID_BIT]),
   .mem_valid_clr(cfsr_clr_i[flt_pkg::MEM_VALID_BIT]),
   .mem_far_o    (mem_far_o)
);

// File: tb/flt_escalate_ctl_test.sv
module flt_escalate_ctl_test;
   localparam int AW = 32;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          flt_mem_i = 0, flt_bus_i = 0, flt_use_i = 0, bus_stk_i = 0;
   logic [AW-1:0] flt_addr_i = '0;
   logic [1:0]    ctx_i = 2'd0;
   logic [PW-1:0] exec_pri_i = 3'd4;
   logic [2:0]    en_i = 3'b111;
   logic [PW-1:0] mem_pri_i = 3'd2, bus_pri_i = 3'd2, use_pri_i = 3'd2;
   logic          nmi_i = 0, dbg_halt_i = 0;
   logic [31:0]   cfsr_clr_i = '0;
   logic [1:0]    hfsr_clr_i = '0;
   logic [4:0]    take_o;
   logic          lockup_o, exec_en_o;
   logic [31:0]   cfsr_o;
   logic [1:0]    hfsr_o;
   logic [AW-1:0] mem_far_o, bus_far_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flt_escalate_ctl #(.AW(AW), .PW(PW)) uut (
      .clk_i(clk), .rst_ni(rst_ni), .flt_mem_i(flt_mem_i), .flt_bus_i(flt_bus_i),
      .flt_use_i(flt_use_i), .bus_stk_i(bus_stk_i), .flt_addr_i(flt_addr_i),
      .ctx_i(ctx_i), .exec_pri_i(exec_pri_i), .en_i(en_i), .mem_pri_i(mem_pri_i),
      .bus_pri_i(bus_pri_i), .use_pri_i(use_pri_i), .nmi_i(nmi_i),
      .dbg_halt_i(dbg_halt_i), .cfsr_clr_i(cfsr_clr_i), .hfsr_clr_i(hfsr_clr_i),
      .take_o(take_o), .lockup_o(lockup_o), .exec_en_o(exec_en_o),
      .cfsr_o(cfsr_o), .hfsr_o(hfsr_o), .mem_far_o(mem_far_o), .bus_far_o(bus_far_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      cfsr_clr_i = '1; hfsr_clr_i = '1;
      @(negedge clk);
      cfsr_clr_i = '0; hfsr_clr_i = '0;
      repeat (6) @(negedge clk);
   endtask

   // drive fault pulses for one cycle; leaves time just after the capturing edge
   task automatic pulse(input logic m, input logic b, input logic u, input logic stk,
                        input logic [AW-1:0] a);
      @(negedge clk);
      flt_mem_i = m; flt_bus_i = b; flt_use_i = u; bus_stk_i = stk; flt_addr_i = a;
      @(negedge clk);
      flt_mem_i = 0; flt_bus_i = 0; flt_use_i = 0; bus_stk_i = 0;
   endtask

   task automatic t_reset();
      check("R1 take", 32'(take_o), 0);
      check("R1 lockup", 32'(lockup_o), 0);
      check("R1 exec_en", 32'(exec_en_o), 1);
      check("R1 cfsr", cfsr_o, 0);
      check("R1 hfsr", 32'(hfsr_o), 0);
   endtask

   task automatic t_own_and_far();
      clear_all();
      pulse(1, 0, 0, 0, 32'hA000_0010);
      check("R2 mem status", cfsr_o, 32'h81);
      check("R9 mem far", mem_far_o, 32'hA000_0010);
      @(negedge clk);
      check("R2 mem take", 32'(take_o), 32'b00100);
      check("R2 no forced", 32'(hfsr_o), 0);
      pulse(1, 0, 0, 0, 32'hB000_0020);
      check("R9 far held", mem_far_o, 32'hA000_0010);
      @(negedge clk);
      cfsr_clr_i = 32'h81;
      @(negedge clk);
      cfsr_clr_i = '0;
      check("R10 cleared", cfsr_o, 0);
      pulse(1, 0, 0, 0, 32'hC000_0030);
      check("R9 far reload", mem_far_o, 32'hC000_0030);
      pulse(0, 0, 1, 0, '0);
      check("R2 use status", cfsr_o & 32'h1_0000, 32'h1_0000);
      @(negedge clk);
      check("R2 use take", 32'(take_o), 32'b10000);
   endtask

   task automatic t_escalate();
      clear_all();
      en_i = 3'b011;
      pulse(0, 0, 1, 0, '0);
      check("R3 forced disabled", 32'(hfsr_o), 1);
      @(negedge clk);
      check("R3 hard take", 32'(take_o), 32'b00010);
      en_i = 3'b111;
      clear_all();
      bus_pri_i = 3'd4;
      pulse(0, 1, 0, 0, 32'h0000_1234);
      check("R3 forced pri", 32'(hfsr_o), 1);
      check("R9 bus far", bus_far_o, 32'h0000_1234);
      check("R9 bus valid", cfsr_o, 32'h8100);
      @(negedge clk);
      check("R3 hard take pri", 32'(take_o), 32'b00010);
      bus_pri_i = 3'd2;
   endtask

   task automatic t_stack();
      clear_all();
      en_i = 3'b101;
      pulse(0, 1, 0, 1, 32'hDEAD_0000);
      check("R8 stk status", cfsr_o, 32'h1100);
      check("R8 no forced", 32'(hfsr_o), 0);
      check("R8 far kept", bus_far_o, 32'h0000_1234);
      @(negedge clk);
      check("R8 bus take", 32'(take_o), 32'b01000);
      en_i = 3'b111;
   endtask

   task automatic t_arb();
      clear_all();
      en_i = 3'b011;
      pulse(0, 0, 1, 0, '0);
      nmi_i = 1;
      @(negedge clk);
      nmi_i = 0;
      check("R7 nmi first", 32'(take_o), 32'b00001);
      @(negedge clk);
      check("R7 hard next", 32'(take_o), 32'b00010);
      en_i = 3'b111;
      pulse(1, 1, 0, 0, 32'h10);
      @(negedge clk);
      check("R7 mem before bus", 32'(take_o), 32'b00100);
      @(negedge clk);
      check("R7 bus after mem", 32'(take_o), 32'b01000);
   endtask

   task automatic t_lock_dbg();
      clear_all();
      ctx_i = 2'd2;
      pulse(1, 0, 0, 0, 32'h20);
      check("R4 lockup", 32'(lockup_o), 1);
      check("R4 exec_en", 32'(exec_en_o), 0);
      check("R4 hfsr", 32'(hfsr_o), 3);
      @(negedge clk);
      check("R4 no take", 32'(take_o), 0);
      cfsr_clr_i = '1;
      @(negedge clk);
      cfsr_clr_i = '0;
      pulse(0, 0, 1, 0, '0);
      @(negedge clk);
      check("R11 ignored", cfsr_o, 0);
      dbg_halt_i = 1;
      @(negedge clk);
      dbg_halt_i = 0;
      check("R5 dbg release", 32'(lockup_o), 0);
      ctx_i = 2'd0;
   endtask

   task automatic t_lock_nmi();
      clear_all();
      ctx_i = 2'd2;
      pulse(0, 0, 1, 0, '0);
      ctx_i = 2'd0;
      @(negedge clk);
      nmi_i = 1;
      @(negedge clk);
      nmi_i = 0;
      check("R6 nmi release", 32'(lockup_o), 0);
      check("R6 nmi taken", 32'(take_o), 32'b00001);
      clear_all();
      ctx_i = 2'd1;
      pulse(0, 0, 1, 0, '0);
      check("R4 lock in nmi", 32'(lockup_o), 1);
      @(negedge clk);
      nmi_i = 1;
      @(negedge clk);
      nmi_i = 0;
      check("R6 nmi no release", 32'(lockup_o), 1);
      check("R6 nmi not taken", 32'(take_o), 0);
      rst_ni = 0;
      #1;
      check("R5 reset release", 32'(lockup_o), 0);
      @(negedge clk);
      rst_ni = 1;
      ctx_i = 2'd0;
   endtask

   task automatic t_set_beats_clear();
      clear_all();
      en_i = 3'b011;
      @(negedge clk);
      flt_use_i = 1; hfsr_clr_i = 2'b01;
      @(negedge clk);
      flt_use_i = 0; hfsr_clr_i = 0;
      check("R10 set wins", 32'(hfsr_o), 1);
      @(negedge clk);
      hfsr_clr_i = 2'b01;
      @(negedge clk);
      hfsr_clr_i = 0;
      check("R10 clear", 32'(hfsr_o), 0);
      en_i = 3'b111;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_ni = 1;
      @(negedge clk);
      t_reset();
      t_own_and_far();
      t_escalate();
      t_stack();
      t_arb();
      t_lock_dbg();
      t_lock_nmi();
      t_set_beats_clear();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule